// File: doc/BRIEF.md
# Add/Subtract Unit with Held Condition Flags

This block is a registered 32-bit integer add/subtract unit that keeps a four-bit condition flag register: negative, zero, carry and overflow. Each operation is presented with a one-cycle valid strobe, two operands, an add/subtract select and a set-flags control. The result appears one clock later. The flag register keeps its value between operations. It is rewritten only by an operation that asks for a flag update and actually executes.

A condition evaluator compares a 4-bit condition code against the held flags and reports pass or fail at any time. The same evaluator gates conditional execution. When an operation is marked conditional and its condition fails against the flags held at issue, the result and the flags are left untouched. The output strobe still acknowledges the operation, and a separate signal shows that it was skipped. Because the flags are registered, an operation issued in the cycle after a flag-setting operation already sees the new flags.

Top module: `arith_flag_unit`

## Requirements
- R1: With op_sub=1, an executed operation writes opnd_a minus opnd_b (modulo 2^32) to result one clock after the in_valid edge.
- R2: With op_sub=0, an executed operation writes opnd_a plus opnd_b (modulo 2^32) to result one clock after the in_valid edge.
- R3: The flag register is unchanged across any clock edge without an executed operation that has set_flags=1. This includes operations issued with set_flags=0.
- R4: On an executed operation with set_flags=1, N (flags[3]) becomes bit 31 of the new result and Z (flags[2]) becomes 1 exactly when the new result is zero.
- R5: On an executed flag-setting operation, C (flags[1]) becomes the carry out of an add. For a subtract it becomes 1 exactly when opnd_a >= opnd_b taken as unsigned values, meaning no borrow.
- R6: On an executed flag-setting operation, V (flags[0]) becomes 1 exactly when the two adder inputs share a sign and the result's sign differs. For a subtract the adder's second input is the bitwise inverse of opnd_b.
- R7: cond_pass reflects the held flags and cond_sel with no clock delay, using this encoding: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 and 15 always pass.
- R8: An operation issued with cond_en=1 while cond_pass=0 leaves result and flags unchanged and gives out_exec=0 in the output cycle. With cond_en=0, or with a passing condition, it executes and gives out_exec=1.
- R9: out_valid is high in exactly the cycle after each in_valid cycle. Synchronous reset clears result, flags, out_valid and out_exec to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| set_flags | input | 1 | 1 = update the flag register from this operation |
| cond_en | input | 1 | 1 = execute only if the selected condition passes |
| cond_sel | input | 4 | Condition code (encoding in R7) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Registered result of the last executed operation |
| flags | output | 4 | Held flags {N, Z, C, V} |
| cond_pass | output | 1 | Selected condition evaluated against the held flags |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_exec | output | 1 | The operation acknowledged by out_valid executed |

## Verification
A vector table drives adds and subtracts whose operands are chosen to separate the four flags. Small positive sums set none of them. An all-ones plus one wraps to zero with carry. The largest positive plus one overflows to negative. Two most-negative values set zero, carry and overflow together. Subtracts cover a larger minus a smaller, a smaller minus a larger, equal operands, and both signed-overflow directions. Each entry therefore tells carry apart from overflow, and borrow apart from sign. Directed steps hold several distinct flag states and sweep all sixteen condition codes in each, so that each code's expression is distinguished from its neighbour. They also issue non-flag-setting and conditionally skipped operations after a flag change, to show that neither result nor flags move when they must not.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int COND_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [2:0] {
    B_ZERO  = 3'd0,
    B_CARRY = 3'd1,
    B_NEG   = 3'd2,
    B_OVF   = 3'd3,
    B_HIGH  = 3'd4,
    B_GEQ   = 3'd5,
    B_GT    = 3'd6,
    B_ALL   = 3'd7
  } cond_base_e;
endpackage

// File: rtl/afu_adder.sv
module afu_adder
  import afu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             sub,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output flags_t           nflags
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    b_eff    = sub ? ~b : b;
    wide     = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    sum      = wide[MSB:0];
    nflags.n = wide[MSB];
    nflags.z = (wide[MSB:0] == '0);
    nflags.c = wide[WIDTH];
    nflags.v = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
  end
endmodule

// File: rtl/afu_cond_eval.sv
module afu_cond_eval
  import afu_pkg::*;
(
  input  flags_t            f,
  input  logic [COND_W-1:0] sel,
  output logic              pass
);
  cond_base_e base;
  logic       raw;

  always_comb begin
    base = cond_base_e'(sel[COND_W-1:1]);
    unique case (base)
      B_ZERO:  raw = f.z;
      B_CARRY: raw = f.c;
      B_NEG:   raw = f.n;
      B_OVF:   raw = f.v;
      B_HIGH:  raw = f.c & ~f.z;
      B_GEQ:   raw = (f.n == f.v);
      B_GT:    raw = ~f.z & (f.n == f.v);
      default: raw = 1'b1;
    endcase
    pass = (base == B_ALL) ? 1'b1 : (raw ^ sel[0]);
  end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic              set_flags,
  input  logic              cond_en,
  input  logic [COND_W-1:0] cond_sel,
  input  logic [WIDTH-1:0]  opnd_a,
  input  logic [WIDTH-1:0]  opnd_b,
  output logic [WIDTH-1:0]  result,
  output logic [3:0]        flags,
  output logic              cond_pass,
  output logic              out_valid,
  output logic              out_exec
);
  flags_t           flag_q;
  flags_t           flag_new;
  logic [WIDTH-1:0] sum;
  logic             exec;

  afu_adder #(.WIDTH(WIDTH)) u_adder (
    .sub    (op_sub),
    .a      (opnd_a),
    .b      (opnd_b),
    .sum    (sum),
    .nflags (flag_new)
  );

  afu_cond_eval u_cond (
    .f    (flag_q),
    .sel  (cond_sel),
    .pass (cond_pass)
  );

  assign exec = in_valid && (!cond_en || cond_pass);

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      flag_q    <= '0;
      out_valid <= 1'b0;
      out_exec  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_exec  <= exec;
      if (exec) begin
        result <= sum;
        if (set_flags) flag_q <= flag_new;
      end
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/afu_checker.sv
module afu_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             op_sub,
  input logic             set_flags,
  input logic             cond_en,
  input logic             cond_pass,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       flags,
  input logic             out_valid,
  input logic             out_exec
);
  a_r1_difference: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_en && op_sub) |=> (result == $past(opnd_a) - $past(opnd_b)));

  a_r2_sum: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_en && !op_sub) |=> (result == $past(opnd_a) + $past(opnd_b)));

  a_r3_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || !set_flags) |=> $stable(flags));

  a_r4_nz_from_result: assert property (@(posedge clk) disable iff (rst)
    (in_valid && set_flags && !cond_en) |=>
      ((flags[3] == result[WIDTH-1]) && (flags[2] == (result == '0))));

  a_r8_skip_holds: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_en && !cond_pass) |=> ($stable(result) && $stable(flags) && !out_exec));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r9_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_exec));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (flags == 4'b0 && result == '0 && !out_valid && !out_exec));
endmodule

bind arith_flag_unit afu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_sub    (op_sub),
  .set_flags (set_flags),
  .cond_en   (cond_en),
  .cond_pass (cond_pass),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .result    (result),
  .flags     (flags),
  .out_valid (out_valid),
  .out_exec  (out_exec)
);

// File: tb/tb_arith_flag_unit.sv
`timescale 1ns/1ps
module tb_arith_flag_unit;
  localparam int W = 32;
  localparam int NV = 10;
  localparam int VW = 1 + W + W + W + 4;

  // {sub, a, b, expected result, expected flags NZCV}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 4'b0000},
    {1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 4'b0110},
    {1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 4'b1001},
    {1'b0, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 4'b0111},
    {1'b1, 32'h0000_0005, 32'h0000_0003, 32'h0000_0002, 4'b0010},
    {1'b1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 4'b1000},
    {1'b1, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 4'b0110},
    {1'b1, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 4'b0011},
    {1'b1, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 4'b1001},
    {1'b0, 32'h1234_5678, 32'h1111_1111, 32'h2345_6789, 4'b0000}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         op_sub = 1'b0;
  logic         set_flags = 1'b0;
  logic         cond_en = 1'b0;
  logic [3:0]   cond_sel = 4'd0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [W-1:0] result;
  logic [3:0]   flags;
  logic         cond_pass;
  logic         out_valid;
  logic         out_exec;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  arith_flag_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .set_flags(set_flags), .cond_en(cond_en), .cond_sel(cond_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .flags(flags),
    .cond_pass(cond_pass), .out_valid(out_valid), .out_exec(out_exec)
  );

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Condition reference written from the encoding table, flags = {N,Z,C,V}
  function automatic bit cond_ref(input int code, input logic [3:0] f);
    bit n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (code)
      0:  return z;
      1:  return !z;
      2:  return c;
      3:  return !c;
      4:  return n;
      5:  return !n;
      6:  return v;
      7:  return !v;
      8:  return c && !z;
      9:  return !c || z;
      10: return n == v;
      11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  // One operation; returns at the negedge where its outputs are visible
  task automatic issue(input bit sub, input bit sf, input bit ce,
                       input logic [3:0] cs, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; op_sub = sub; set_flags = sf; cond_en = ce;
    cond_sel = cs; opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0; set_flags = 1'b0; cond_en = 1'b0;
  endtask

  task automatic sweep_conds(input logic [3:0] f);
    for (int k = 0; k < 16; k++) begin
      cond_sel = 4'(k);
      #0.5;
      check(cond_pass == cond_ref(k, f), $sformatf("R7 code %0d", k),
            W'(cond_pass), W'(cond_ref(k, f)));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held_r;
    logic [3:0]   held_f;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check(result == '0, "R9 reset result", result, '0);
    check(flags == 4'b0, "R9 reset flags", W'(flags), '0);
    check(!out_valid && !out_exec, "R9 reset strobes", W'({out_valid, out_exec}), '0);

    // R1 R2 R4 R5 R6: vector table
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      issue(e[VW-1], 1'b1, 1'b0, 4'd0, e[VW-2 -: W], e[VW-2-W -: W]);
      check(result == e[W+3:4], e[VW-1] ? "R1 difference" : "R2 sum",
            result, e[W+3:4]);
      check(flags[3:2] == e[3:2], "R4 N/Z flags", W'(flags), W'(e[3:0]));
      check(flags[1] == e[1], "R5 carry flag", W'(flags), W'(e[3:0]));
      check(flags[0] == e[0], "R6 overflow flag", W'(flags), W'(e[3:0]));
      check(out_valid && out_exec, "R9 strobes after op", W'({out_valid, out_exec}), W'(2'b11));
    end
    @(negedge clk);
    check(!out_valid, "R9 out_valid drops when idle", W'(out_valid), '0);

    // R7: condition sweep in several flag states
    issue(1'b1, 1'b1, 1'b0, 4'd0, 32'd5, 32'd5);       // 0110
    sweep_conds(4'b0110);
    issue(1'b0, 1'b1, 1'b0, 4'd0, 32'h7FFF_FFFF, 32'd1); // 1001
    sweep_conds(4'b1001);
    issue(1'b1, 1'b1, 1'b0, 4'd0, 32'd3, 32'd5);       // 1000
    sweep_conds(4'b1000);
    issue(1'b1, 1'b1, 1'b0, 4'd0, 32'h8000_0000, 32'd1); // 0011
    sweep_conds(4'b0011);

    // R3: set_flags low keeps flags while result changes
    issue(1'b1, 1'b1, 1'b0, 4'd0, 32'd9, 32'd9);       // flags 0110
    issue(1'b0, 1'b0, 1'b0, 4'd0, 32'h8000_0000, 32'h8000_0000);
    check(flags == 4'b0110, "R3 flags held with set_flags low", W'(flags), W'(4'b0110));
    check(result == 32'd0, "R2 sum with set_flags low", result, 32'd0);
    issue(1'b1, 1'b0, 1'b0, 4'd0, 32'd1, 32'd2);
    check(flags == 4'b0110, "R3 flags held after subtract", W'(flags), W'(4'b0110));
    check(result == 32'hFFFF_FFFF, "R1 difference no flags", result, 32'hFFFF_FFFF);

    // R8: Z=1 held; NE fails -> skipped, EQ passes -> executes
    held_r = result; held_f = flags;
    issue(1'b0, 1'b1, 1'b1, 4'd1, 32'd7, 32'd8);
    check(result == held_r, "R8 skipped result held", result, held_r);
    check(flags == held_f, "R8 skipped flags held", W'(flags), W'(held_f));
    check(out_valid && !out_exec, "R8 skip strobes", W'({out_valid, out_exec}), W'(2'b10));
    issue(1'b0, 1'b1, 1'b1, 4'd0, 32'd7, 32'd8);
    check(result == 32'd15 && out_exec, "R8 passing condition executes", result, 32'd15);
    check(flags == 4'b0000, "R8 executed op set flags", W'(flags), '0);
    // back-to-back: flags from previous op gate the next one (Z now 0, EQ fails)
    issue(1'b1, 1'b1, 1'b1, 4'd0, 32'd1, 32'd1);
    check(result == 32'd15 && !out_exec, "R8 new flags gate next op", result, 32'd15);

    // R9: reset mid-run clears state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(result == '0 && flags == 4'b0, "R9 reset clears", result, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule